// File: doc/BRIEF.md
# Monitor Packet Duration Limiter

This block limits how long a bus monitor may keep one recording packet open in its message stack. The host programs a 16-bit duration limit. While a packet is open, a prescaler divides the system clock into 10 µs ticks, and an elapsed counter counts those ticks. When the count reaches the limit, the block raises a one-cycle request that tells the stack logic to finalize the packet.

The limit is in units of 10 µs. A value of 10,000 gives exactly 100 ms, and 0xFFFF gives 655.35 ms. A limit of zero turns time-based closing off. The limit only acts in packetized recording mode, which is selected when the mode input is 0.

Two resets affect the block in different ways. The hard master reset clears the limit register. The monitor soft reset clears only the timing state and drops the open packet; the limit register keeps its value.

Top module: `pkt_duration_limiter`

## Requirements
- R1: Hard reset (`rst` high) clears the limit register to 0, so `host_rd_data` reads 0, and it holds `finalize_req` low.
- R2: When `host_wr_en` is high at a clock edge, that edge stores `host_wr_data` into the limit register, and `host_rd_data` shows the new value from the next cycle.
- R3: A monitor soft reset (`mon_soft_rst` high) leaves the limit register unchanged.
- R4: Suppose `pkt_start` is sampled at edge E0 and the limit is L (nonzero, packetized mode). Then `finalize_req` is high for exactly the cycle that follows edge E0 + L·CLK_PER_10US.
- R5: `finalize_req` is a single-cycle pulse. It is issued at most once per packet, even if the packet stays open afterwards.
- R6: A limit value of 0 never produces `finalize_req`.
- R7: When `cfg_mode_bit` is 1 (not packetized recording), `finalize_req` is never asserted.
- R8: `pkt_close` ends the open packet and clears the elapsed time. No request follows, and the next packet is timed from its own start.
- R9: A `pkt_start` while a packet is open restarts timing from that start.
- R10: Suppose the host writes a limit at or below the current elapsed count while a packet is open. Then `finalize_req` follows the next 10 µs tick.
- R11: A monitor soft reset drops the open packet. No request is issued until a new `pkt_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Hard master reset, synchronous, active high |
| mon_soft_rst | input | 1 | Monitor-only soft reset, synchronous, active high |
| cfg_mode_bit | input | 1 | Recording mode: 0 = packetized (limit active), 1 = other |
| host_wr_en | input | 1 | Host write strobe for the limit register |
| host_wr_data | input | LIMIT_W (16) | Host write data |
| host_rd_data | output | LIMIT_W (16) | Current limit register value |
| pkt_start | input | 1 | A new recording packet opens |
| pkt_close | input | 1 | The open packet closed for any reason |
| finalize_req | output | 1 | One-cycle request to finalize the open packet |

## Verification
The assertions check, on every cycle, the properties that depend only on the previous cycle. These are: the pulse lasts one cycle; no request follows a zero limit, the other mode, a close or a soft reset; and the register survives a soft reset and is cleared by a hard one. The exact request cycle depends on the prescaler ratio times the limit, so only the bench scenarios can show it. The same holds for the once-per-packet rule over a long open packet, the restart on a repeated start, and the early request after the limit is lowered below the elapsed count.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

  typedef enum logic {
    REC_PACKETIZED = 1'b0,
    REC_OTHER      = 1'b1
  } rec_mode_e;

  function automatic logic [15:0] sat_inc16(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

endpackage

// File: rtl/pdl_limit_reg.sv
module pdl_limit_reg #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [LIMIT_W-1:0] wr_data,
  output logic [LIMIT_W-1:0] limit
);
  // Only the hard reset reaches this register; the soft reset is not wired in.
  always_ff @(posedge clk) begin
    if (rst)        limit <= '0;
    else if (wr_en) limit <= wr_data;
  end
endmodule

// File: rtl/pdl_prescaler.sv
module pdl_prescaler #(
  parameter int DIV = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = run & ~clr;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      assign tick = run & ~clr & (cnt == LAST);

      always_ff @(posedge clk) begin
        if (rst || clr || !run) cnt <= '0;
        else if (cnt == LAST)   cnt <= '0;
        else                    cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/pdl_elapsed.sv
module pdl_elapsed #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               tick,
  output logic [LIMIT_W-1:0] count_next
);
  localparam logic [LIMIT_W-1:0] MAXV = '1;
  logic [LIMIT_W-1:0] count_q;

  // Saturating: the count stops at the all-ones value.
  assign count_next = (count_q == MAXV) ? count_q : count_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) count_q <= '0;
    else if (tick)  count_q <= count_next;
  end
endmodule

// File: rtl/pdl_fire.sv
module pdl_fire #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               tick,
  input  logic               enable,
  input  logic [LIMIT_W-1:0] count_next,
  input  logic [LIMIT_W-1:0] limit,
  output logic               fire
);
  logic fired_q;
  logic hit;

  // The compare uses >=, so a limit lowered below the count fires on the next tick.
  assign hit = tick & enable & ~clr & ~fired_q &
               (limit != '0) & (count_next >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      fire    <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      fire    <= hit;
      fired_q <= clr ? 1'b0 : (fired_q | hit);
    end
  end
endmodule

// File: rtl/pkt_duration_limiter.sv
module pkt_duration_limiter
  import pdl_pkg::*;
#(
  parameter int LIMIT_W      = 16,
  parameter int CLK_PER_10US = 500
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mon_soft_rst,
  input  logic               cfg_mode_bit,
  input  logic               host_wr_en,
  input  logic [LIMIT_W-1:0] host_wr_data,
  output logic [LIMIT_W-1:0] host_rd_data,
  input  logic               pkt_start,
  input  logic               pkt_close,
  output logic               finalize_req
);
  logic               open_q;
  logic               tmr_clr;
  logic               tick;
  logic               enable;
  logic [LIMIT_W-1:0] limit;
  logic [LIMIT_W-1:0] count_next;
  rec_mode_e          mode;

  assign mode    = rec_mode_e'(cfg_mode_bit);
  assign enable  = open_q & (mode == REC_PACKETIZED);
  assign tmr_clr = mon_soft_rst | pkt_start | pkt_close;

  // Packet-open state. A start wins over a close in the same cycle.
  always_ff @(posedge clk) begin
    if (rst || mon_soft_rst) open_q <= 1'b0;
    else if (pkt_start)      open_q <= 1'b1;
    else if (pkt_close)      open_q <= 1'b0;
  end

  pdl_limit_reg #(.LIMIT_W(LIMIT_W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(host_wr_en),
    .wr_data(host_wr_data), .limit(limit)
  );

  pdl_prescaler #(.DIV(CLK_PER_10US)) u_pre (
    .clk(clk), .rst(rst), .clr(tmr_clr), .run(open_q), .tick(tick)
  );

  pdl_elapsed #(.LIMIT_W(LIMIT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(tmr_clr | ~open_q),
    .tick(tick), .count_next(count_next)
  );

  pdl_fire #(.LIMIT_W(LIMIT_W)) u_fire (
    .clk(clk), .rst(rst), .clr(tmr_clr), .tick(tick),
    .enable(enable), .count_next(count_next), .limit(limit),
    .fire(finalize_req)
  );

  assign host_rd_data = limit;
endmodule

// File: rtl/pdl_checker.sv
module pdl_checker #(
  parameter int LIMIT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               mon_soft_rst,
  input logic               cfg_mode_bit,
  input logic               host_wr_en,
  input logic [LIMIT_W-1:0] host_rd_data,
  input logic               pkt_close,
  input logic               pkt_start,
  input logic               finalize_req
);
  p_hard_clear_r1: assert property (@(posedge clk)
    rst |=> (host_rd_data == '0) && !finalize_req);

  p_soft_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (mon_soft_rst && !host_wr_en) |=> $stable(host_rd_data));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    finalize_req |=> !finalize_req);

  p_zero_limit_r6: assert property (@(posedge clk) disable iff (rst)
    (host_rd_data == '0) |=> !finalize_req);

  p_mode_gate_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_mode_bit |=> !finalize_req);

  p_close_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (pkt_close && !pkt_start) |=> !finalize_req);

  p_soft_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    mon_soft_rst |=> !finalize_req);
endmodule

bind pkt_duration_limiter pdl_checker #(.LIMIT_W(LIMIT_W)) u_chk (
  .clk(clk), .rst(rst), .mon_soft_rst(mon_soft_rst),
  .cfg_mode_bit(cfg_mode_bit), .host_wr_en(host_wr_en),
  .host_rd_data(host_rd_data), .pkt_close(pkt_close),
  .pkt_start(pkt_start), .finalize_req(finalize_req)
);

// File: tb/pkt_duration_limiter_bench.sv
module pkt_duration_limiter_bench;
  localparam int W = 16;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mon_soft_rst = 1'b0;
  logic         cfg_mode_bit = 1'b0;
  logic         host_wr_en = 1'b0;
  logic [W-1:0] host_wr_data = '0;
  logic [W-1:0] host_rd_data;
  logic         pkt_start = 1'b0;
  logic         pkt_close = 1'b0;
  logic         finalize_req;

  typedef struct {
    int    cyc;
    string req;
  } exp_t;

  exp_t  exp_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  int    pulses = 0;
  bit    done = 1'b0;
  string cur_req = "R5";

  always #10 clk = ~clk;   // 50 MHz

  pkt_duration_limiter #(.LIMIT_W(W), .CLK_PER_10US(N)) u_pkt_duration_limiter (
    .clk(clk), .rst(rst), .mon_soft_rst(mon_soft_rst),
    .cfg_mode_bit(cfg_mode_bit), .host_wr_en(host_wr_en),
    .host_wr_data(host_wr_data), .host_rd_data(host_rd_data),
    .pkt_start(pkt_start), .pkt_close(pkt_close),
    .finalize_req(finalize_req)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: each request pulse is matched against the expected queue.
  always @(negedge clk) begin
    if (!rst && finalize_req) begin
      exp_t e;
      pulses++;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected finalize at cycle %0d (expected none)", cur_req, cyc);
      end else begin
        e = exp_q.pop_front();
        if (e.cyc != cyc) begin
          fails++;
          $display("FAIL %s: finalize at cycle %0d, expected %0d", e.req, cyc, e.cyc);
        end
      end
    end
  end

  task automatic push_exp(input int c, input string r);
    exp_t e;
    e.cyc = c;
    e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic wr_limit(input logic [W-1:0] v);
    @(negedge clk); host_wr_en = 1'b1; host_wr_data = v;
    @(negedge clk); host_wr_en = 1'b0;
  endtask

  task automatic start_pkt(output int k);
    @(negedge clk); pkt_start = 1'b1; k = cyc;
    @(negedge clk); pkt_start = 1'b0;
  endtask

  task automatic close_pkt();
    @(negedge clk); pkt_close = 1'b1;
    @(negedge clk); pkt_close = 1'b0;
  endtask

  task automatic check_rd(input string r, input logic [W-1:0] e);
    @(negedge clk);
    checks++;
    if (host_rd_data !== e) begin
      fails++;
      $display("FAIL %s: host_rd_data=%h expected %h", r, host_rd_data, e);
    end
  endtask

  task automatic expect_quiet(input string r, input int n);
    int p0;
    p0 = pulses;
    cur_req = r;
    repeat (n) @(negedge clk);
    checks++;
    if (pulses != p0) begin
      fails++;
      $display("FAIL %s: %0d pulses in quiet window, expected 0", r, pulses - p0);
    end
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    int k;
    int k2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (finalize_req !== 1'b0) begin
      fails++;
      $display("FAIL R1: finalize_req=%b expected 0", finalize_req);
    end
    check_rd("R1", 16'h0000);

    // R2, R4, R5: basic timing with limit 3
    wr_limit(16'd3);
    check_rd("R2", 16'd3);
    start_pkt(k);
    push_exp(k + 1 + 3 * N, "R4");
    wait_cyc(k + 1 + 3 * N + 1);
    expect_quiet("R5", 60);
    close_pkt();

    // R6: zero limit
    wr_limit(16'd0);
    start_pkt(k);
    expect_quiet("R6", 100);
    close_pkt();

    // R7: other mode
    wr_limit(16'd2);
    cfg_mode_bit = 1'b1;
    start_pkt(k);
    expect_quiet("R7", 50);
    close_pkt();
    cfg_mode_bit = 1'b0;
    repeat (2) @(negedge clk);

    // R8: early close, then a fresh packet timed from its own start
    start_pkt(k);
    repeat (5) @(negedge clk);
    close_pkt();
    expect_quiet("R8", 30);
    start_pkt(k2);
    push_exp(k2 + 1 + 2 * N, "R8");
    wait_cyc(k2 + 1 + 2 * N + 3);
    close_pkt();

    // R9: restart while open
    start_pkt(k);
    repeat (5) @(negedge clk);
    start_pkt(k2);
    push_exp(k2 + 1 + 2 * N, "R9");
    wait_cyc(k2 + 1 + 2 * N + 3);
    close_pkt();

    // R10: limit lowered below elapsed count (3 ticks elapsed, new limit 2)
    wr_limit(16'd10);
    start_pkt(k);
    wait_cyc(k + 14);
    host_wr_en = 1'b1; host_wr_data = 16'd2;
    @(negedge clk); host_wr_en = 1'b0;
    push_exp(k + 17, "R10");
    wait_cyc(k + 20);
    close_pkt();

    // R11, R3: soft reset drops the packet, keeps the limit
    wr_limit(16'd5);
    start_pkt(k);
    repeat (10) @(negedge clk);
    mon_soft_rst = 1'b1;
    @(negedge clk); mon_soft_rst = 1'b0;
    expect_quiet("R11", 60);
    check_rd("R3", 16'd5);
    start_pkt(k2);
    push_exp(k2 + 1 + 5 * N, "R3");
    wait_cyc(k2 + 1 + 5 * N + 3);
    close_pkt();

    // R1: hard reset mid-run clears the register
    wr_limit(16'd7);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check_rd("R1", 16'h0000);

    repeat (5) @(negedge clk);
    while (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      fails++;
      $display("FAIL %s: no finalize seen, expected at cycle %0d", e.req, e.cyc);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule